// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns characters into asynchronous serial frames on a single transmit line. Each frame has a low start bit, then 5 to 9 data bits sent least significant bit first, an optional parity position, a stop period of 1, 1.5 or 2 bit times, and an optional run of extra idle bit times called the guard period. Software hands one character at a time to a holding stage. The bit engine takes the character from there as soon as it is idle, so software can place the next character while the current one is still being shifted out.

Timing comes from an oversampling tick that an external baud generator supplies. One bit time is `OVS` ticks. The frame format is read from the configuration inputs when a character leaves the holding stage. A frame that is already on the line therefore keeps its format if the configuration changes. For multidrop buses, an address-request pulse marks the next written character as an address: in the multidrop parity mode the parity position then carries 1 instead of 0. A transmitter-reset pulse drops everything in flight and returns the line to idle.

Top module: `ctx_char_tx`

## Requirements
- R1: After reset the line is high (idle), `hold_ready` is 1 and `tx_empty` is 1.
- R2: A frame starts with one bit time low and then sends the data LSB first. When `cfg_nine` is 0, the number of data bits is `cfg_len_code` + 5 (code 0 gives 5 bits, code 3 gives 8 bits). The line goes low on the cycle after the cycle in which an idle transmitter accepts a write.
- R3: When `cfg_nine` is 1, nine data bits are sent, whatever the value of `cfg_len_code`.
- R4: `cfg_parity` selects what follows the data. 0 sends even parity (the data bits plus the parity bit hold an even number of ones). 1 sends odd parity. 2 sends a fixed 0 and 3 sends a fixed 1. 4 and 5 send no parity position. 6 and 7 select multidrop.
- R5: `cfg_stop` sets the high stop period: 0 gives `OVS` ticks, 1 gives 3·`OVS`/2 ticks, and 2 or 3 give 2·`OVS` ticks.
- R6: `cfg_guard` = N adds N extra high bit times (N·`OVS` ticks) after the stop period of every frame.
- R7: In multidrop mode the parity position is 1 for a character marked as an address and 0 otherwise. A pulse on `send_addr` marks the next accepted write, and that write consumes the mark.
- R8: A write (`wr_en`) is accepted only while `hold_ready` is 1. A write while `hold_ready` is 0 is ignored, and no frame is ever sent for it.
- R9: `tx_empty` is 1 only when the holding stage is empty and no frame is on the line. If a second character is waiting, it follows the first frame without `tx_empty` rising in between.
- R10: A `tx_reset` pulse aborts the current frame. On the next cycle the line is high, `hold_ready` is 1 and `tx_empty` is 1. Any held character and any pending address mark are discarded.
- R11: Bit timing advances only on cycles where `os_tick` is 1. Without ticks a low line stays low, and a frame at half the tick rate lasts twice as many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick from the baud generator |
| cfg_len_code | input | 2 | Data length minus 5 (used when `cfg_nine` is 0) |
| cfg_nine | input | 1 | Selects 9-bit characters; overrides `cfg_len_code` |
| cfg_parity | input | 3 | Parity selection (see R4) |
| cfg_stop | input | 2 | Stop period selection (see R5) |
| cfg_guard | input | GUARD_W | Extra idle bit times after each stop period |
| send_addr | input | 1 | Pulse: mark the next written character as an address |
| tx_reset | input | 1 | Pulse: abort the transmitter and discard the held character |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Character to send; bits above the length are ignored |
| tx_line | output | 1 | Serial transmit line, high when idle |
| hold_ready | output | 1 | Holding stage can take a character |
| tx_empty | output | 1 | Holding stage and bit engine both idle |

## Verification
The bench builds the block with `OVS` = 4 and `GUARD_W` = 8. With `OVS` = 4, even the longest frame it drives (9 data bits, parity, 2 stop bits and a 3-bit guard) takes only 64 cycles, so every length, every parity code, every stop option and several guard counts can each be run frame by frame. Because 4 is even, the 1.5-bit stop period is a whole 6 ticks and its length can be checked exactly. With a tick on every cycle, frame lengths can be counted in cycles. A half-rate tick pattern then shows that timing follows the tick and not the clock.

// File: rtl/ctx_pkg.sv
// Package ctx_pkg
// Shared constants and types for the character transmitter.
// Assumes characters are at most 9 bits and the guard count fits in 8 bits.
package ctx_pkg;

    localparam int MAX_BITS = 9;
    localparam int NB_W     = 4;
    localparam int GUARD_W  = 8;

    // Parity selection codes
    localparam logic [2:0] PAR_EVEN  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_ZERO  = 3'd2;
    localparam logic [2:0] PAR_ONE   = 3'd3;

    // Stop period selection codes (3 behaves as 2)
    localparam logic [1:0] STOP_ONE  = 2'd0;
    localparam logic [1:0] STOP_HALF = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_GUARD = 3'd5
    } eng_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] bits;
        logic [NB_W-1:0]     nbits;
        logic                par_en;
        logic                par_val;
        logic [1:0]          stop_sel;
        logic [GUARD_W-1:0]  guard;
    } frame_t;

endpackage

// File: rtl/ctx_hold_stage.sv
// Module ctx_hold_stage
// One-entry holding register between the writer and the bit engine.
// It also keeps the pending address mark, which the next accepted write consumes.
// Assumes take is raised only while full is 1. Abort has priority over everything.
module ctx_hold_stage
    import ctx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic                addr_cmd,
    input  logic                take,
    output logic                full,
    output logic [MAX_BITS-1:0] data,
    output logic                addr
);

    logic pending;
    logic accept;

    // A write is accepted only into an empty stage
    assign accept = wr_en && !full;

    // Occupancy flag: set by an accepted write, cleared when the engine takes the entry
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Character and address-mark capture on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            addr <= 1'b0;
        end else if (accept) begin
            data <= wr_data;
            addr <= pending || addr_cmd;
        end
    end

    // Pending address mark: set by the command, consumed by the next accepted write
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            pending <= 1'b0;
        end else if (accept) begin
            pending <= 1'b0;
        end else if (addr_cmd) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/ctx_frame_form.sv
// Module ctx_frame_form
// Combinational frame descriptor builder. It sets the data length (the 9-bit
// flag has priority over the length code), masks unused data bits, works out
// the parity position, and passes on the stop and guard selections.
// Assumes its inputs are stable in the cycle the engine loads the descriptor.
module ctx_frame_form
    import ctx_pkg::*;
(
    input  logic [MAX_BITS-1:0] data,
    input  logic                addr,
    input  logic [1:0]          len_code,
    input  logic                nine,
    input  logic [2:0]          parity,
    input  logic [1:0]          stop_sel,
    input  logic [GUARD_W-1:0]  guard,
    output frame_t              frame
);

    logic [NB_W-1:0]     nb;
    logic [MAX_BITS-1:0] mask;
    logic                ones_odd;

    // Effective length and the mask of the data bits that are sent
    always_comb begin
        nb = nine ? NB_W'(MAX_BITS) : (NB_W'(len_code) + NB_W'(5));
        for (int i = 0; i < MAX_BITS; i++) begin
            mask[i] = (NB_W'(i) < nb);
        end
    end

    // Parity fold over the sent data bits
    always_comb begin
        ones_odd = ^(data & mask);
    end

    // Descriptor assembly, including the parity code decode
    always_comb begin
        frame.bits     = data & mask;
        frame.nbits    = nb;
        frame.stop_sel = stop_sel;
        frame.guard    = guard;
        frame.par_en   = 1'b1;
        case (parity)
            PAR_EVEN: frame.par_val = ones_odd;
            PAR_ODD:  frame.par_val = !ones_odd;
            PAR_ZERO: frame.par_val = 1'b0;
            PAR_ONE:  frame.par_val = 1'b1;
            3'd4, 3'd5: begin
                frame.par_en  = 1'b0;
                frame.par_val = 1'b0;
            end
            default:  frame.par_val = addr;
        endcase
    end

endmodule

// File: rtl/ctx_bit_engine.sv
// Module ctx_bit_engine
// Frame sequencer and shifter. It loads a descriptor from the holding stage
// when idle, then walks through start, data, parity, stop and guard, counting
// OVS oversampling ticks per bit time (3*OVS/2 for the 1.5-bit stop period).
// Assumes OVS is even and at least 2. Abort returns it to idle at once.
module ctx_bit_engine
    import ctx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   abort,
    input  logic   os_tick,
    input  logic   avail,
    input  frame_t frame,
    output logic   take,
    output logic   busy,
    output logic   line
);

    localparam int LIM_W = $clog2(2 * OVS + 1);
    localparam logic [LIM_W-1:0] LIM_ONE  = LIM_W'(OVS);
    localparam logic [LIM_W-1:0] LIM_HALF = LIM_W'((3 * OVS) / 2);
    localparam logic [LIM_W-1:0] LIM_TWO  = LIM_W'(2 * OVS);

    eng_state_e          state;
    logic [LIM_W-1:0]    cnt;
    logic [LIM_W-1:0]    lim;
    logic                bit_end;
    logic [MAX_BITS-1:0] shreg;
    logic [NB_W-1:0]     bits_left;
    logic                par_en;
    logic                par_val;
    logic [1:0]          stop_sel;
    logic [GUARD_W-1:0]  guard_left;

    assign take = (state == ST_IDLE) && avail;
    assign busy = (state != ST_IDLE);

    // Tick count that ends the current bit time
    always_comb begin
        if (state == ST_STOP) begin
            case (stop_sel)
                STOP_ONE:  lim = LIM_ONE;
                STOP_HALF: lim = LIM_HALF;
                default:   lim = LIM_TWO;
            endcase
        end else begin
            lim = LIM_ONE;
        end
    end

    assign bit_end = os_tick && (cnt == lim - LIM_W'(1));

    // Oversampling tick counter within the current bit time
    always_ff @(posedge clk) begin
        if (!rst_n || abort || state == ST_IDLE) begin
            cnt <= '0;
        end else if (os_tick) begin
            cnt <= bit_end ? '0 : cnt + LIM_W'(1);
        end
    end

    // Frame sequencing, data shifting and descriptor capture
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bits_left  <= '0;
            par_en     <= 1'b0;
            par_val    <= 1'b0;
            stop_sel   <= STOP_ONE;
            guard_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (avail) begin
                        state      <= ST_START;
                        shreg      <= frame.bits;
                        bits_left  <= frame.nbits - NB_W'(1);
                        par_en     <= frame.par_en;
                        par_val    <= frame.par_val;
                        stop_sel   <= frame.stop_sel;
                        guard_left <= frame.guard;
                    end
                end
                ST_START: begin
                    if (bit_end) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (bits_left == '0) begin
                            state <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            bits_left <= bits_left - NB_W'(1);
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_end) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (guard_left != '0) begin
                            state      <= ST_GUARD;
                            guard_left <= guard_left - GUARD_W'(1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_GUARD: begin
                    if (bit_end) begin
                        if (guard_left == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            guard_left <= guard_left - GUARD_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line level selected by the frame position
    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_val;
            default:  line = 1'b1;
        endcase
    end

endmodule

// File: rtl/ctx_char_tx.sv
// Module ctx_char_tx
// Top level of the configurable asynchronous character transmitter: holding
// stage, frame descriptor builder and bit engine.
// Assumes os_tick comes from an external baud generator at OVS ticks per bit
// time, and that configuration is held steady while a character is loaded.
module ctx_char_tx
    import ctx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic [1:0]          cfg_len_code,
    input  logic                cfg_nine,
    input  logic [2:0]          cfg_parity,
    input  logic [1:0]          cfg_stop,
    input  logic [GUARD_W-1:0]  cfg_guard,
    input  logic                send_addr,
    input  logic                tx_reset,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    output logic                tx_line,
    output logic                hold_ready,
    output logic                tx_empty
);

    logic                hold_full;
    logic [MAX_BITS-1:0] hold_data;
    logic                hold_addr;
    logic                eng_take;
    logic                eng_busy;
    frame_t              next_frame;

    ctx_hold_stage u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (tx_reset),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .addr_cmd (send_addr),
        .take     (eng_take),
        .full     (hold_full),
        .data     (hold_data),
        .addr     (hold_addr)
    );

    ctx_frame_form u_form (
        .data     (hold_data),
        .addr     (hold_addr),
        .len_code (cfg_len_code),
        .nine     (cfg_nine),
        .parity   (cfg_parity),
        .stop_sel (cfg_stop),
        .guard    (cfg_guard),
        .frame    (next_frame)
    );

    ctx_bit_engine #(.OVS(OVS)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (tx_reset),
        .os_tick (os_tick),
        .avail   (hold_full),
        .frame   (next_frame),
        .take    (eng_take),
        .busy    (eng_busy),
        .line    (tx_line)
    );

    assign hold_ready = !hold_full;
    assign tx_empty   = !hold_full && !eng_busy;

endmodule

// File: rtl/ctx_char_tx_chk.sv
// Module ctx_char_tx_chk
// Port-level protocol checker for ctx_char_tx, attached with bind.
// Assumes a synchronous active-low reset held from time zero.
module ctx_char_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic tx_reset,
    input logic wr_en,
    input logic tx_line,
    input logic hold_ready,
    input logic tx_empty
);

    // R9: an empty transmitter keeps the line idle
    p_empty_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_line);

    // R9: an empty transmitter can always take a character
    p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_ready);

    // R10: the abort command leaves everything idle on the next cycle
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> (tx_line && hold_ready && tx_empty));

    // R8: an accepted write makes the transmitter non-empty
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_ready && !tx_reset) |=> !tx_empty);

    // R2: a write into an idle transmitter starts the frame on the next cycle
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_empty) && !tx_reset) |=> !tx_line);

    // R11: without a tick a low line stays low
    p_hold_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_tick && !tx_reset && !tx_line) |=> !tx_line);

endmodule

bind ctx_char_tx ctx_char_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .tx_reset   (tx_reset),
    .wr_en      (wr_en),
    .tx_line    (tx_line),
    .hold_ready (hold_ready),
    .tx_empty   (tx_empty)
);

// File: tb/ctx_char_tx_tb_top.sv
// Directed bench for ctx_char_tx: one task per scenario, each checking its own results.
module ctx_char_tx_tb_top;
    import ctx_pkg::*;

    localparam int OVS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       tick_alt = 1'b0;
    logic [1:0] cfg_len_code = 2'd3;
    logic       cfg_nine = 1'b0;
    logic [2:0] cfg_parity = 3'd4;
    logic [1:0] cfg_stop = 2'd0;
    logic [7:0] cfg_guard = 8'd0;
    logic       send_addr = 1'b0;
    logic       tx_reset = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_line;
    logic       hold_ready;
    logic       tx_empty;

    int  n_checks = 0;
    int  n_errors = 0;
    logic samp [0:255];
    logic end_empty;
    logic early_empty;

    always #4 clk = ~clk;

    // Tick pattern: every cycle, or every other cycle
    always @(negedge clk) os_tick <= tick_alt ? ~os_tick : 1'b1;

    ctx_char_tx #(.OVS(OVS)) dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .cfg_len_code(cfg_len_code), .cfg_nine(cfg_nine), .cfg_parity(cfg_parity),
        .cfg_stop(cfg_stop), .cfg_guard(cfg_guard), .send_addr(send_addr),
        .tx_reset(tx_reset), .wr_en(wr_en), .wr_data(wr_data),
        .tx_line(tx_line), .hold_ready(hold_ready), .tx_empty(tx_empty)
    );

    task automatic ck(input logic cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_addr();
        @(negedge clk); send_addr = 1'b1;
        @(negedge clk); send_addr = 1'b0;
    endtask

    function automatic int n_bits();
        return cfg_nine ? 9 : int'(cfg_len_code) + 5;
    endfunction

    function automatic int has_par();
        return (cfg_parity == 3'd4 || cfg_parity == 3'd5) ? 0 : 1;
    endfunction

    function automatic int stop_ticks();
        return (cfg_stop == 2'd0) ? OVS : (cfg_stop == 2'd1) ? (3 * OVS) / 2 : 2 * OVS;
    endfunction

    function automatic int frame_ticks();
        return (1 + n_bits() + has_par()) * OVS + stop_ticks() + int'(cfg_guard) * OVS;
    endfunction

    function automatic logic exp_par(input logic [8:0] d, input logic is_addr);
        int ones = 0;
        for (int i = 0; i < n_bits(); i++) ones += int'(d[i]);
        case (cfg_parity)
            3'd0: return logic'(ones % 2);
            3'd1: return logic'(1 - ones % 2);
            3'd2: return 1'b0;
            3'd3: return 1'b1;
            default: return is_addr;
        endcase
    endfunction

    // Record one frame from its first low sample over dur cycles, then sample tx_empty once more
    task automatic capture(input int dur);
        int guard_n = 0;
        early_empty = 1'b0;
        do begin
            @(negedge clk);
            guard_n++;
        end while (tx_line && guard_n < 300);
        samp[0] = tx_line;
        for (int i = 1; i < dur; i++) begin
            @(negedge clk);
            samp[i] = tx_line;
            if (tx_empty) early_empty = 1'b1;
        end
        @(negedge clk);
        end_empty = tx_empty;
    endtask

    // Compare a captured frame with the expected start, data, parity and stop/guard levels
    task automatic check_frame(input string req, input logic [8:0] d, input logic is_addr,
                               input logic exp_end_empty);
        int nb = n_bits();
        int hp = has_par();
        int body = (1 + nb + hp) * OVS;
        int dur = frame_ticks();
        logic [10:0] got = '0;
        logic [10:0] exp = '0;
        logic tail_ok = 1'b1;
        for (int b = 0; b < 1 + nb + hp; b++) got[b] = samp[b * OVS + OVS / 2];
        exp[0] = 1'b0;
        for (int b = 0; b < nb; b++) exp[1 + b] = d[b];
        if (hp != 0) exp[1 + nb] = exp_par(d, is_addr);
        for (int i = body; i < dur; i++) if (!samp[i]) tail_ok = 1'b0;
        ck(got == exp, {req, " bits"}, int'(got), int'(exp));
        ck(tail_ok, {req, " stop/guard high"}, int'(tail_ok), 1);
        ck(!early_empty && end_empty == exp_end_empty, {req, " R9 empty"},
           int'(end_empty), int'(exp_end_empty));
    endtask

    task automatic send_and_check(input string req, input logic [8:0] d);
        do_write(d);
        capture(frame_ticks());
        check_frame(req, d, 1'b0, 1'b1);
    endtask

    task automatic t_reset_state();
        ck(tx_line == 1'b1, "R1 line", int'(tx_line), 1);
        ck(hold_ready == 1'b1, "R1 ready", int'(hold_ready), 1);
        ck(tx_empty == 1'b1, "R1 empty", int'(tx_empty), 1);
    endtask

    task automatic t_lengths();
        cfg_parity = 3'd4; cfg_stop = 2'd0; cfg_guard = 0; cfg_nine = 1'b0;
        for (int l = 0; l < 4; l++) begin
            cfg_len_code = 2'(l);
            send_and_check("R2 length", 9'h1A5 ^ 9'(l * 37));
        end
    endtask

    task automatic t_nine();
        cfg_nine = 1'b1; cfg_len_code = 2'd0; cfg_parity = 3'd4;
        send_and_check("R3 nine-bit", 9'h1C3);
        send_and_check("R3 nine-bit msb0", 9'h05A);
        cfg_nine = 1'b0; cfg_len_code = 2'd3;
    endtask

    task automatic t_parity();
        for (int p = 0; p < 6; p++) begin
            cfg_parity = 3'(p);
            send_and_check("R4 parity", 9'h0B7);
            send_and_check("R4 parity alt", 9'h034);
        end
    endtask

    task automatic t_stop();
        cfg_parity = 3'd0;
        for (int s = 0; s < 4; s++) begin
            cfg_stop = 2'(s);
            send_and_check("R5 stop", 9'h0E1);
        end
        cfg_stop = 2'd0;
    endtask

    task automatic t_guard();
        cfg_parity = 3'd1;
        for (int g = 1; g < 4; g++) begin
            cfg_guard = 8'(g);
            send_and_check("R6 guard", 9'h066);
        end
        cfg_guard = 8'd0;
    endtask

    task automatic t_multidrop();
        cfg_parity = 3'd6; cfg_len_code = 2'd3;
        pulse_addr();
        do_write(9'h012);
        capture(frame_ticks());
        check_frame("R7 address mark", 9'h012, 1'b1, 1'b1);
        do_write(9'h0F3);
        capture(frame_ticks());
        check_frame("R7 data after address", 9'h0F3, 1'b0, 1'b1);
        cfg_parity = 3'd7;
        pulse_addr();
        do_write(9'h0F3);
        capture(frame_ticks());
        check_frame("R7 address code 7", 9'h0F3, 1'b1, 1'b1);
        cfg_parity = 3'd4;
    endtask

    task automatic t_ready();
        cfg_parity = 3'd4;
        // A write while the holding stage is full is ignored
        @(negedge clk); wr_en = 1'b1; wr_data = 9'h0AA;
        @(negedge clk); wr_data = 9'h055;
        ck(hold_ready == 1'b0, "R8 not ready after write", int'(hold_ready), 0);
        @(negedge clk); wr_en = 1'b0;
        capture(frame_ticks() - 1);
        check_frame("R8 ignored write", 9'h0AA, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        ck(tx_line == 1'b1 && tx_empty == 1'b1, "R8 no frame for ignored write",
           int'(tx_line), 1);
        // A second character written while the first is sent follows back to back
        fork
            begin
                capture(frame_ticks());
                check_frame("R9 first of two", 9'h0C9, 1'b0, 1'b0);
                capture(frame_ticks());
                check_frame("R9 second of two", 9'h036, 1'b0, 1'b1);
            end
            begin
                do_write(9'h0C9);
                repeat (3) @(negedge clk);
                do_write(9'h036);
            end
        join
    endtask

    task automatic t_abort();
        cfg_parity = 3'd6;
        do_write(9'h081);
        repeat (3) @(negedge clk);
        do_write(9'h07E);
        repeat (6) @(negedge clk);
        tx_reset = 1'b1;
        @(negedge clk);
        tx_reset = 1'b0;
        ck(tx_line == 1'b1, "R10 line after abort", int'(tx_line), 1);
        ck(hold_ready == 1'b1 && tx_empty == 1'b1, "R10 flags after abort",
           int'({hold_ready, tx_empty}), 3);
        begin
            logic stayed = 1'b1;
            repeat (40) begin
                @(negedge clk);
                if (!tx_line) stayed = 1'b0;
            end
            ck(stayed, "R10 held char discarded", int'(stayed), 1);
        end
        pulse_addr();
        @(negedge clk); tx_reset = 1'b1;
        @(negedge clk); tx_reset = 1'b0;
        do_write(9'h0F0);
        capture(frame_ticks());
        check_frame("R10 address mark cleared", 9'h0F0, 1'b0, 1'b1);
        cfg_parity = 3'd4;
    endtask

    task automatic t_tick_rate();
        int t0 = 0;
        int cyc = 0;
        int exp2;
        cfg_parity = 3'd0;
        tick_alt = 1'b1;
        repeat (4) @(negedge clk);
        do_write(9'h0D2);
        while (tx_line) begin
            @(negedge clk);
            t0++;
            if (t0 > 300) break;
        end
        while (!tx_empty && cyc < 600) begin
            @(negedge clk);
            cyc++;
        end
        exp2 = 2 * frame_ticks();
        ck(cyc >= exp2 - 2 && cyc <= exp2 + 2, "R11 half tick rate", cyc, exp2);
        tick_alt = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        #1000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_lengths();
        t_nine();
        t_parity();
        t_stop();
        t_guard();
        t_multidrop();
        t_ready();
        t_abort();
        t_tick_rate();
        finish_run();
    end

endmodule